// File: doc/BRIEF.md
# Two-Stage Watchdog Reset Timer

This block guards a processor against runaway software. A down counter steps once for every instruction-clock tick and wraps to all ones after reaching zero. Such a wrap is a timeout. A timeout does not reset the system at once. The first timeout only arms an alert flag. A second timeout that arrives while the alert is still armed fires a one-cycle system reset pulse and latches a tripped flag. Software keeps the system alive by issuing a service strobe often enough. The strobe disarms the alert, so a single timeout between two services is harmless.

While the system sits in its RAM back-up state the oscillator is stopped. A hold input models that state, and the counter is frozen while it is high. The reset pulse is a plain output. The surrounding reset logic is expected to feed it back into `rst_n`. Only `rst_n` returns the counter and both flags to their starting values.

Top module: `wdt_two_stage`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `alert_o`, `tripped_o` and `sys_reset_o` are 0 and the counter holds its full value of all ones.
- R2: The counter steps down by one on each clock edge where `tick_en_i` is 1 and `hold_i` is 0. A timeout occurs on the 2^CNT_W-th such step counted from reset or from the previous timeout. At a timeout the counter wraps to all ones and keeps counting.
- R3: `service_i` high at an edge with no timeout clears `alert_o` after that edge. The strobe leaves the counter and `tripped_o` unchanged.
- R4: A timeout while `alert_o` is 0 sets `alert_o` after that edge and does not raise `sys_reset_o`.
- R5: A timeout while `alert_o` is 1, with no service strobe at the same edge, raises `sys_reset_o` for exactly one cycle and sets `tripped_o`. `alert_o` stays 1.
- R6: When a service strobe and a timeout fall on the same edge, the strobe is taken first. No reset pulse is produced, and `alert_o` is 1 after the edge.
- R7: While `hold_i` is 1 the counter does not move, whatever `tick_en_i` does, and no timeout can occur.
- R8: `tripped_o` stays 1 until `rst_n` goes low. A service strobe does not clear it.
- R9: At an edge where `tick_en_i` is 0 the counter keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | Instruction-clock enable; one count step per high cycle |
| service_i | input | 1 | Software service strobe; disarms the alert |
| hold_i | input | 1 | RAM back-up (oscillator stopped) indication; freezes counting |
| sys_reset_o | output | 1 | One-cycle system reset request |
| alert_o | output | 1 | First-stage flag: one timeout seen since the last service |
| tripped_o | output | 1 | Second-stage flag: a reset has been requested since `rst_n` |

## Verification
Two functions can meet on one edge: the timeout that escalates the flags, and the service strobe that disarms them. The bench tracks its own copy of the count. It waits until that count shows zero with the alert armed, then raises the service strobe together with a tick, so that both land on the same edge. The cycle is judged correct when no reset pulse appears and the alert reads 1 afterwards. A plain timeout with the alert armed must still produce the pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // What the escalation logic does at one edge
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_ARM   = 2'd1,
    EV_TRIP  = 2'd2,
    EV_CLEAR = 2'd3
  } wdt_event_e;

  typedef struct packed {
    logic stage1;
    logic stage2;
  } wdt_flags_t;

endpackage

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ZERO = {CNT_W{1'b0}};

  logic [CNT_W-1:0] count_q;

  // Decrementing past zero wraps to FULL, which is the reload value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= FULL;
    else if (step_i) count_q <= count_q - 1'b1;
  end

  assign count_o = count_q;
  assign wrap_o  = step_i && (count_q == ZERO);

endmodule

// File: rtl/wdt_escalate.sv
module wdt_escalate
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrap_i,
  input  logic       service_i,
  output wdt_flags_t flags_o,
  output logic       trip_o
);

  wdt_flags_t flags_q;
  logic       trip_q;
  wdt_event_e ev;

  // A timeout takes precedence over a plain service. A service on the
  // same edge as a timeout counts as having come just before it.
  always_comb begin
    if (wrap_i) begin
      ev = (flags_q.stage1 && !service_i) ? EV_TRIP : EV_ARM;
    end else if (service_i) begin
      ev = EV_CLEAR;
    end else begin
      ev = EV_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      trip_q  <= 1'b0;
    end else begin
      trip_q <= (ev == EV_TRIP);
      case (ev)
        EV_ARM:   flags_q.stage1 <= 1'b1;
        EV_TRIP:  flags_q.stage2 <= 1'b1;
        EV_CLEAR: flags_q.stage1 <= 1'b0;
        default:  ;
      endcase
    end
  end

  assign flags_o = flags_q;
  assign trip_o  = trip_q;

endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
  parameter int CNT_W = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en_i,
  input  logic service_i,
  input  logic hold_i,
  output logic sys_reset_o,
  output logic alert_o,
  output logic tripped_o
);

  import wdt_pkg::*;

  logic             step;
  logic             wrap;
  logic [CNT_W-1:0] count;
  wdt_flags_t       flags;
  logic             trip;

  assign step = tick_en_i && !hold_i;

  wdt_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_i  (step),
    .count_o (count),
    .wrap_o  (wrap)
  );

  wdt_escalate u_esc (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrap_i    (wrap),
    .service_i (service_i),
    .flags_o   (flags),
    .trip_o    (trip)
  );

  assign sys_reset_o = trip;
  assign alert_o     = flags.stage1;
  assign tripped_o   = flags.stage2;

endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk #(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en_i,
  input logic             service_i,
  input logic             hold_i,
  input logic             sys_reset_o,
  input logic             alert_o,
  input logic             tripped_o,
  input logic             wrap,
  input logic [CNT_W-1:0] count
);

  p_service_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (service_i && !wrap) |=> !alert_o);

  p_first_timeout_arms_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !alert_o) |=> (alert_o && !sys_reset_o));

  p_second_timeout_trips_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && alert_o && !service_i) |=> (sys_reset_o && tripped_o && alert_o));

  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_o |=> !sys_reset_o);

  p_collision_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && service_i) |=> (alert_o && !sys_reset_o));

  p_hold_freezes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(count));

  p_tripped_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tripped_o |=> tripped_o);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en_i |=> $stable(count));

endmodule

bind wdt_two_stage wdt_two_stage_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_en_i   (tick_en_i),
  .service_i   (service_i),
  .hold_i      (hold_i),
  .sys_reset_o (sys_reset_o),
  .alert_o     (alert_o),
  .tripped_o   (tripped_o),
  .wrap        (wrap),
  .count       (count)
);

// File: tb/wdt_two_stage_test.sv
`timescale 1ns/1ps
module wdt_two_stage_test;

  localparam int W    = 10;
  localparam int FULL = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, svc = 1'b0, hold = 1'b0;
  logic sys_rst, alert, tripped;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit cmp_en = 1'b0;
  string phase_tag = "R1";

  // behavioural reference state
  int m_cnt = FULL;
  bit m_s1 = 0, m_s2 = 0, m_rst = 0;

  wdt_two_stage #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en_i(tick), .service_i(svc),
    .hold_i(hold), .sys_reset_o(sys_rst), .alert_o(alert), .tripped_o(tripped)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Reference model, updated at each edge from the inputs held since the last falling edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = FULL; m_s1 = 0; m_s2 = 0; m_rst = 0;
    end else begin
      bit tmo;
      tmo = tick && !hold && (m_cnt == 0);
      if (tick && !hold) m_cnt = (m_cnt == 0) ? FULL : m_cnt - 1;
      m_rst = tmo && m_s1 && !svc;
      if (m_rst) m_s2 = 1;
      if (tmo) m_s1 = 1;
      else if (svc) m_s1 = 0;
    end
  end

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      chk({phase_tag, " sys_reset_o"}, sys_rst, m_rst);
      chk({phase_tag, " alert_o"}, alert, m_s1);
      chk({phase_tag, " tripped_o"}, tripped, m_s2);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    // R1: reset values
    chk("R1 alert", alert, 1'b0);
    chk("R1 tripped", tripped, 1'b0);
    chk("R1 sys_reset", sys_rst, 1'b0);
    rst_n = 1'b1;
    cmp_en = 1'b1;

    // R2, R4: first timeout on tick 2^W
    phase_tag = "R2";
    tick = 1'b1;
    step(FULL);
    chk("R2 no timeout before 2^W ticks", alert, 1'b0);
    step(1);
    chk("R4 alert after first timeout", alert, 1'b1);
    chk("R4 no reset on first timeout", sys_rst, 1'b0);

    // R3: service disarms
    phase_tag = "R3";
    svc = 1'b1; step(1); svc = 1'b0;
    chk("R3 service clears alert", alert, 1'b0);
    chk("R3 service keeps tripped", tripped, 1'b0);

    // R5: two timeouts without service
    phase_tag = "R5";
    for (int i = 0; i < 4000 && !alert; i++) step(1);
    chk("R5 re-armed", alert, 1'b1);
    for (int i = 0; i < 4000 && !sys_rst; i++) step(1);
    chk("R5 pulse raised", sys_rst, 1'b1);
    chk("R5 tripped set", tripped, 1'b1);
    chk("R5 alert stays", alert, 1'b1);
    step(1);
    chk("R5 pulse one cycle", sys_rst, 1'b0);

    // R8: tripped survives service
    phase_tag = "R8";
    svc = 1'b1; step(1); svc = 1'b0;
    chk("R8 tripped after service", tripped, 1'b1);
    step(5);
    chk("R8 tripped still set", tripped, 1'b1);

    // reset again
    rst_n = 1'b0; tick = 1'b0;
    step(2);
    chk("R1 alert after re-reset", alert, 1'b0);
    chk("R1 tripped after re-reset", tripped, 1'b0);
    rst_n = 1'b1;

    // R9: sparse ticks
    phase_tag = "R9";
    for (int i = 0; i < 3 * (FULL + 1) + 10; i++) begin
      tick = (i % 3 == 0);
      step(1);
    end
    chk("R9 sparse ticks armed alert", alert, 1'b1);

    // R7: hold with ticks one step before a timeout
    phase_tag = "R7";
    tick = 1'b1;
    for (int i = 0; i < 4000 && m_cnt != 1; i++) step(1);
    hold = 1'b1;
    begin
      logic a0, t0;
      a0 = alert; t0 = tripped;
      step(3000);
      chk("R7 alert frozen in hold", alert, a0);
      chk("R7 tripped frozen in hold", tripped, t0);
      chk("R7 no pulse in hold", sys_rst, 1'b0);
    end
    hold = 1'b0;
    step(1);
    chk("R7 no timeout one tick after hold", sys_rst, 1'b0);
    step(1);
    chk("R7 timeout on second tick after hold", sys_rst, 1'b1);

    // R6: service on the timeout edge, alert armed
    phase_tag = "R6";
    step(1);
    for (int i = 0; i < 4000 && !(m_cnt == 0 && alert); i++) step(1);
    chk("R6 reached armed zero", alert, 1'b1);
    svc = 1'b1; step(1); svc = 1'b0;
    chk("R6 no pulse on collision", sys_rst, 1'b0);
    chk("R6 alert set after collision", alert, 1'b1);
    step(4);

    cmp_en = 1'b0;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule